// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block computes a 32-bit multiply or divide over many clock cycles and keeps the outcome in two 32-bit result registers: an upper half (HI) and a lower half (LO). A multiply writes the full 64-bit product across HI:LO. A divide writes the remainder to HI and the quotient to LO. Each operation comes in a two's-complement variant and in an unsigned variant.

A single-cycle start pulse launches an operation. The operation select and both operands are sampled together with that pulse. The unit first spends one cycle preparing the operand magnitudes. It then runs one iteration per operand bit. Multiply iterations are shift-and-add steps. Divide iterations are restoring steps, where a trial subtraction is dropped whenever it would go negative. A final cycle applies the sign correction and writes HI and LO.

Busy is high for the whole run, and done is high for one cycle when the results appear. The unit performs no divide-by-zero and no overflow detection. Those cases finish in the normal time, and the results are whatever the iteration naturally leaves behind.

Top module: `mdu_core`

## Requirements
- R1: After a synchronous reset, busy_o and done_o are low and hi_o and lo_o are zero.
- R2: Operation code 2'b00 is a signed multiply. {hi_o, lo_o} holds the 64-bit two's-complement product of a_i and b_i.
- R3: Operation code 2'b01 is an unsigned multiply. {hi_o, lo_o} holds the 64-bit unsigned product.
- R4: Operation code 2'b11 is an unsigned divide. lo_o holds a_i / b_i and hi_o holds a_i % b_i.
- R5: Operation code 2'b10 is a signed divide, built by dividing the magnitudes without sign. The quotient is negated when the operand signs differ. The remainder is negated when the dividend is negative. As a result, 0x80000000 / 0xFFFFFFFF gives lo_o = 0x80000000 and hi_o = 0.
- R6: A zero divisor finishes in the normal time. The unsigned divide gives lo_o = 0xFFFFFFFF and hi_o = a_i. The signed divide gives hi_o = a_i, with lo_o = 0xFFFFFFFF for a non-negative dividend and lo_o = 1 for a negative one.
- R7: busy_o rises in the cycle after the edge that samples start_i and stays high for exactly 34 cycles.
- R8: done_o is high for exactly one cycle. That cycle is the first one with busy_o low again, and hi_o and lo_o already show the new result in it.
- R9: hi_o and lo_o change only in a cycle where done_o is high. They hold their values while an operation runs and while the unit is idle.
- R10: A start_i pulse while busy_o is high is ignored. Neither the running result nor its timing is affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, taken only while idle |
| op_i | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Product upper half or remainder |
| lo_o | output | 32 | Product lower half or quotient |

## Verification
A wrong iteration count or a stuck state machine shows up at once as a busy window that is not 34 cycles long. A done pulse in the wrong place shows up the same way. A corrupted accumulator, a wrong restore decision or a lost carry stays hidden until the done cycle. It then appears as a wrong HI or LO value, so every operation's result is compared exactly. Sign fix-up errors show only for signed operations whose operand signs match the flawed case, so the stimulus covers every sign combination, the most negative value and zero divisors.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int MDU_W = 32;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIX
    } mdu_state_e;

    // Per-operation context captured during setup
    typedef struct packed {
        mdu_op_e op;
        logic    neg_a;
        logic    neg_b;
    } mdu_job_t;

    function automatic logic op_is_div(mdu_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_signed(mdu_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
    import mdu_pkg::*;
#(
    parameter int W = MDU_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output mdu_state_e state,
    output logic       accept,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mdu_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic done_q;

    assign accept = start && (st_q == ST_IDLE);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (accept) st_d = ST_SETUP;
            ST_SETUP: st_d = ST_ITER;
            ST_ITER:  if (cnt_q == LAST) st_d = ST_FIX;
            ST_FIX:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_FIX);
            if (st_q == ST_ITER) cnt_q <= cnt_q + 1'b1;
            else                 cnt_q <= '0;
        end
    end

    assign state = st_q;
    assign busy  = (st_q != ST_IDLE);
    assign done  = done_q;

endmodule

// File: rtl/mdu_mul_step.sv
// One shift-and-add iteration: the low half holds the remaining multiplier
// bits, the high half the running partial product.
module mdu_mul_step
    import mdu_pkg::*;
#(
    parameter int W = MDU_W
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] acc_next
);
    logic [W:0] sum;

    always_comb begin
        sum      = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);
        acc_next = {sum, acc[W-1:1]};
    end

endmodule

// File: rtl/mdu_div_step.sv
// One restoring division iteration: high half is the partial remainder,
// low half shifts out dividend bits and shifts in quotient bits.
module mdu_div_step
    import mdu_pkg::*;
#(
    parameter int W = MDU_W
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] acc_next
);
    logic [W:0]   rem_sh;
    logic [W+1:0] trial;
    logic         went_neg;
    logic [W-1:0] rem_new;

    always_comb begin
        rem_sh   = acc[2*W-1:W-1];
        trial    = {1'b0, rem_sh} - {2'b00, dvs};
        went_neg = trial[W+1];
        // Negative trial: restore, i.e. keep the shifted remainder
        rem_new  = went_neg ? rem_sh[W-1:0] : trial[W-1:0];
        acc_next = {rem_new, acc[W-2:0], ~went_neg};
    end

endmodule

// File: rtl/mdu_fixup.sv
module mdu_fixup
    import mdu_pkg::*;
#(
    parameter int W = MDU_W
) (
    input  mdu_job_t       job,
    input  logic [2*W-1:0] acc,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    logic sgn;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;

    always_comb begin
        sgn  = op_is_signed(job.op);
        prod = (sgn && (job.neg_a ^ job.neg_b)) ? -acc : acc;
        quo  = (sgn && (job.neg_a ^ job.neg_b)) ? -acc[W-1:0] : acc[W-1:0];
        rem  = (sgn && job.neg_a) ? -acc[2*W-1:W] : acc[2*W-1:W];
        if (op_is_div(job.op)) begin
            hi = rem;
            lo = quo;
        end else begin
            hi = prod[2*W-1:W];
            lo = prod[W-1:0];
        end
    end

endmodule

// File: rtl/mdu_core.sv
module mdu_core
    import mdu_pkg::*;
#(
    parameter int W = MDU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    mdu_state_e state;
    logic       accept;

    mdu_op_e        op_q;
    logic [W-1:0]   a_q, b_q;
    mdu_job_t       job_q;
    logic [2*W-1:0] acc_q;
    logic [W-1:0]   opd_q;
    logic [W-1:0]   hi_q, lo_q;

    logic [2*W-1:0] mul_next, div_next;
    logic [W-1:0]   fix_hi, fix_lo;
    logic           sa, sb;
    logic [W-1:0]   mag_a, mag_b;

    mdu_seq #(.W(W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .state  (state),
        .accept (accept),
        .busy   (busy_o),
        .done   (done_o)
    );

    mdu_mul_step #(.W(W)) u_mul (
        .acc      (acc_q),
        .mcand    (opd_q),
        .acc_next (mul_next)
    );

    mdu_div_step #(.W(W)) u_div (
        .acc      (acc_q),
        .dvs      (opd_q),
        .acc_next (div_next)
    );

    mdu_fixup #(.W(W)) u_fix (
        .job (job_q),
        .acc (acc_q),
        .hi  (fix_hi),
        .lo  (fix_lo)
    );

    always_comb begin
        sa    = op_is_signed(op_q) && a_q[W-1];
        sb    = op_is_signed(op_q) && b_q[W-1];
        mag_a = sa ? -a_q : a_q;
        mag_b = sb ? -b_q : b_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_MULS;
            a_q   <= '0;
            b_q   <= '0;
            job_q <= '0;
            acc_q <= '0;
            opd_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q <= mdu_op_e'(op_i);
                        a_q  <= a_i;
                        b_q  <= b_i;
                    end
                end
                ST_SETUP: begin
                    job_q <= '{op: op_q, neg_a: sa, neg_b: sb};
                    if (op_is_div(op_q)) begin
                        acc_q <= {{W{1'b0}}, mag_a};
                        opd_q <= mag_b;
                    end else begin
                        acc_q <= {{W{1'b0}}, mag_b};
                        opd_q <= mag_a;
                    end
                end
                ST_ITER: begin
                    acc_q <= op_is_div(job_q.op) ? div_next : mul_next;
                end
                ST_FIX: begin
                    hi_q <= fix_hi;
                    lo_q <= fix_lo;
                end
                default: ;
            endcase
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    localparam int LAT = W + 2;
    localparam int LW  = $clog2(LAT + 2);

    logic [LW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)         busy_len <= '0;
        else if (busy_o) busy_len <= busy_len + 1'b1;
        else             busy_len <= '0;
    end

    // R7: an idle start raises busy on the next cycle
    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R7, R10: the busy window is always exactly LAT cycles
    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_len == LW'(LAT)));

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: done falls in an idle cycle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R9: results move only with done
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({hi_o, lo_o}) |-> done_o);

endmodule

bind mdu_core mdu_core_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/test_mdu_core.sv
module test_mdu_core;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [1:0]  op_i;
    logic [31:0] a_i, b_i;
    logic        busy_o, done_o;
    logic [31:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mdu_core i_mdu_core (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .hi_o    (hi_o),
        .lo_o    (lo_o)
    );

    function automatic logic [63:0] expect_res(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        logic sa, sb;
        logic [31:0] ma, mb, q, r;
        logic [63:0] p;
        case (op)
            2'b00: begin
                p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
                return p;
            end
            2'b01: begin
                p = {32'b0, a} * {32'b0, b};
                return p;
            end
            default: begin
                sa = (op == 2'b10) && a[31];
                sb = (op == 2'b10) && b[31];
                ma = sa ? -a : a;
                mb = sb ? -b : b;
                if (mb == 0) begin
                    q = 32'hFFFF_FFFF;
                    r = ma;
                end else begin
                    q = ma / mb;
                    r = ma % mb;
                end
                if (sa ^ sb) q = -q;
                if (sa) r = -r;
                return {r, q};
            end
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one operation; optionally pulses a second start mid-run.
    task automatic run_op(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                          string req, bit intrude);
        logic [63:0] exp, prev;
        int n;
        bit held;
        exp  = expect_res(op, a, b);
        prev = {hi_o, lo_o};
        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        a_i = ~a; b_i = b ^ 32'h5A5A_0001; op_i = ~op;
        n = 0;
        held = 1'b1;
        while (busy_o && n < 100) begin
            n++;
            if ({hi_o, lo_o} != prev) held = 1'b0;
            if (intrude && n == 10) start_i = 1'b1;
            if (intrude && n == 11) start_i = 1'b0;
            @(negedge clk);
        end
        chk(n == 34, "R7", "busy cycles", 64'(n), 64'd34);
        chk(held, "R9", "hold during run", {hi_o, lo_o}, prev);
        chk(done_o == 1'b1, "R8", "done at end", 64'(done_o), 64'd1);
        chk({hi_o, lo_o} == exp, req, "result", {hi_o, lo_o}, exp);
        if (intrude) chk({hi_o, lo_o} == exp, "R10", "ignored start", {hi_o, lo_o}, exp);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done single", {62'b0, done_o, busy_o}, 64'd0);
        chk({hi_o, lo_o} == exp, "R9", "hold idle", {hi_o, lo_o}, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] rop;
        logic [31:0] ra, rb;
        string rq;
        void'($urandom(32'd1234));
        rst = 1'b1; start_i = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && !done_o && hi_o == 0 && lo_o == 0, "R1", "reset state",
            {busy_o, done_o, hi_o, lo_o[29:0]}, 64'd0);

        // Directed corners
        run_op(2'b00, 32'hFFFF_FFFD, 32'd7, "R2", 1'b0);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R2", 1'b0);
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 1'b0);
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", 1'b0);
        run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R3", 1'b0);
        run_op(2'b11, 32'd100, 32'd7, "R4", 1'b0);
        run_op(2'b11, 32'hFFFF_FFFF, 32'h8000_0000, "R4", 1'b0);
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, "R5", 1'b0);
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, "R5", 1'b0);
        run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5", 1'b0);
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R5", 1'b0);
        run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R6", 1'b0);
        run_op(2'b10, 32'd42, 32'd0, "R6", 1'b0);
        run_op(2'b10, 32'hFFFF_FFD6, 32'd0, "R6", 1'b0);
        run_op(2'b01, 32'd3000, 32'd5000, "R10", 1'b1);
        run_op(2'b10, 32'hFFFF_0000, 32'd9, "R10", 1'b1);

        // Random mix
        for (int i = 0; i < 80; i++) begin
            rop = 2'($urandom_range(0, 3));
            ra  = $urandom;
            rb  = $urandom;
            if (i % 7 == 3) rb = rb & 32'h0000_00FF;
            if (i % 11 == 5) ra = 32'h8000_0000;
            case (rop)
                2'b00: rq = "R2";
                2'b01: rq = "R3";
                2'b10: rq = "R5";
                default: rq = "R4";
            endcase
            run_op(rop, ra, rb, rq, (i % 9 == 0));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule